// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block sits on the host side of a management link and turns one high-level register request into the full series of management-port transactions that a paged, indirectly addressed register space needs. A request names a page, an 8-bit register offset, a direction and a width code (8, 16, 32, 48 or 64 bits), plus write data when it writes. The sequencer writes the data words when needed, selects the page, issues the command and polls the command register for completion. On a read it then collects the data words. It ends with a one-cycle done pulse that carries the assembled read data and an error flag.

All transactions go to one fixed PHY address (default 0x1E). The block remembers the page it last selected. A request to that same page skips the page-select transaction. After reset the remembered page is 0xFF, a value never used as a real page, so the first request always selects its page. Completion polling is bounded: after a busy poll the block waits `poll_gap` idle cycles and then polls again. It gives up with an error if the fifth poll still reads busy. Any management transaction that returns an error ends the request at once.

States: IDLE (waits for a request), DATA_WR (writes data words), PAGE_WR (selects the page), CMD_WR (issues the command), POLL_RD (reads the command register), POLL_WAIT (idles between polls), DATA_RD (reads data words), FINISH (pulses done). Transitions:
- IDLE→DATA_WR on an accepted write.
- IDLE→PAGE_WR on an accepted read to a new page.
- IDLE→CMD_WR on an accepted read to the remembered page.
- DATA_WR→PAGE_WR or DATA_WR→CMD_WR after the last data word. PAGE_WR is taken only when the page changes.
- PAGE_WR→CMD_WR.
- CMD_WR→POLL_RD.
- POLL_RD→POLL_WAIT on a busy poll when `poll_gap` is non-zero.
- POLL_RD→POLL_RD on a busy poll when `poll_gap` is zero.
- POLL_WAIT→POLL_RD when the gap expires.
- POLL_RD→DATA_RD on completion of a read.
- POLL_RD→FINISH on completion of a write, or on timeout.
- DATA_RD→FINISH after the last data word.
- Any transaction state→FINISH on a management error.
- FINISH→IDLE.

Top module: `pg_reg_seq`

## Requirements
- R1: After reset `req_ready` is 1, `mg_valid` and `done` are 0, and the remembered page is 0xFF, so the first request performs a page-select write.
- R2: When the requested page differs from the remembered page, the block writes `{page, 8'h01}` to register 0x10 and then remembers that page. When the pages match, this write is skipped. Every transaction uses PHY address 0x1E.
- R3: The command write puts `{offset, 8'h01}` (write) or `{offset, 8'h02}` (read) into register 0x11.
- R4: After the command write, the block reads register 0x11 until bits 1:0 are both 0. If the fifth poll still has either bit set, the request ends with `done_err`=1 and no data-register reads.
- R5: Between the completion of a busy poll and the start of the next poll, `mg_valid` stays low for exactly `poll_gap` cycles.
- R6: A write first puts its data into registers 0x18 upward, least significant 16-bit word first. These writes come before the page-select and command writes. Width code 0 (8 bit) and 1 (16 bit) use one word, 2 (32 bit) two, 3 (48 bit) three, and 4 (64 bit) four.
- R7: After completion, a read fetches registers 0x18 upward, one per word. Register 0x18+i lands in `done_rdata` bits 16i+15:16i. For width code 0 only bits 7:0 are kept.
- R8: A management transaction that completes with `mg_err`=1 ends the request immediately with `done_err`=1. A failed page-select write leaves the remembered page unchanged.
- R9: `req_ready` is high only in IDLE. A request is taken when `req_valid` and `req_ready` are both high, and no further request is taken until `done`.
- R10: `done` is a one-cycle pulse. `done_rdata` is 0 for writes and for failed requests.
- R11: `mg_valid` stays high with `mg_reg` and `mg_wdata` stable until the cycle in which `mg_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_page | input | 8 | Target page |
| req_offset | input | 8 | Register offset within the page |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 3 | Width code: 0=8, 1=16, 2=32, 3=48, 4=64 bits |
| req_wdata | input | 64 | Write data, least significant bits first |
| poll_gap | input | GAP_W | Idle cycles inserted after a busy poll |
| mg_valid | output | 1 | Management transaction request |
| mg_write | output | 1 | 1 = management write, 0 = read |
| mg_phy | output | 5 | PHY address of the transaction |
| mg_reg | output | 5 | Register number of the transaction |
| mg_wdata | output | 16 | Management write data |
| mg_done | input | 1 | Transaction complete (one cycle) |
| mg_err | input | 1 | Transaction failed, valid with mg_done |
| mg_rdata | input | 16 | Management read data, valid with mg_done |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_err | output | 1 | Request failed, valid with done |
| done_rdata | output | 64 | Assembled read data, valid with done |

## Verification
The bench's management responder answers each transaction exactly `lat` cycles after it first sees `mg_valid`, and it time-stamps each transaction at that first sighting. A busy poll completing with gap g must therefore be followed by the next poll stamp exactly lat+2+g cycles later. The bench checks that spacing for every poll pair. The done pulse lasts one cycle, so the bench samples all outputs on falling edges. It reads `done_rdata` and `done_err` on the falling edge where `done` is high. It checks `req_ready` on the falling edge right after the accepting edge. The ordered transaction log is compared with a sequence that the bench builds from the request, its own copy of the remembered page, the busy count and the injected error index.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    localparam int DATA_W = 64;
    localparam int WORD_W = 16;
    localparam int NWORDS = DATA_W / WORD_W;
    localparam int IDX_W  = $clog2(NWORDS);

    localparam logic [4:0] REG_PAGE  = 5'h10;
    localparam logic [4:0] REG_CMD   = 5'h11;
    localparam logic [4:0] REG_DATA0 = 5'h18;

    localparam logic [7:0] PAGE_NONE = 8'hFF;
    localparam logic [2:0] WID_8     = 3'd0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DATA_WR,
        S_PAGE_WR,
        S_CMD_WR,
        S_POLL_RD,
        S_POLL_WAIT,
        S_DATA_RD,
        S_FINISH
    } seq_state_t;

    function automatic logic [2:0] words_for(input logic [2:0] wcode);
        case (wcode)
            3'd0, 3'd1: words_for = 3'd1;
            3'd2:       words_for = 3'd2;
            3'd3:       words_for = 3'd3;
            default:    words_for = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pgseq_wait.sv
module pgseq_wait #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= gap;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == GAP_W'(1));

endmodule

// File: rtl/pgseq_gather.sv
module pgseq_gather
    import pgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [WORD_W-1:0] cap_word,
    input  logic              byte_only,
    input  logic              suppress,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (cap_en) begin
            acc_q[cap_idx*WORD_W +: WORD_W] <= cap_word;
        end
    end

    always_comb begin
        if (suppress) begin
            rdata = '0;
        end else if (byte_only) begin
            rdata = {{(DATA_W-8){1'b0}}, acc_q[7:0]};
        end else begin
            rdata = acc_q;
        end
    end

endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
    import pgseq_pkg::*;
#(
    parameter int POLL_MAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_page,
    input  logic [7:0]        req_offset,
    input  logic              req_write,
    input  logic [2:0]        req_width,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mg_valid,
    output logic              mg_write,
    output logic [4:0]        mg_reg,
    output logic [WORD_W-1:0] mg_wdata,
    input  logic              mg_done,
    input  logic              mg_err,
    input  logic [1:0]        poll_status,
    input  logic              gap_zero,
    output logic              wait_start,
    input  logic              wait_expired,
    output logic              clr,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              byte_only,
    output logic              suppress,
    output logic              done,
    output logic              done_err
);

    localparam int PCNT_W = $clog2(POLL_MAX + 1);

    seq_state_t        state_q, state_d;
    logic [7:0]        page_q, off_q, cache_q;
    logic              wr_q;
    logic [2:0]        width_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [PCNT_W-1:0] poll_q;
    logic              err_q;

    logic xfer_ok, xfer_bad, poll_busy, timeout, page_new, is_last;

    assign last_idx  = IDX_W'(words_for(width_q) - 3'd1);
    assign is_last   = (idx_q == last_idx);
    assign xfer_ok   = mg_done && !mg_err;
    assign xfer_bad  = mg_done && mg_err;
    assign poll_busy = (poll_status != 2'b00);
    assign page_new  = (page_q != cache_q);
    assign timeout   = (state_q == S_POLL_RD) && xfer_ok && poll_busy &&
                       (poll_q == PCNT_W'(POLL_MAX - 1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write)                  state_d = S_DATA_WR;
                    else if (req_page != cache_q)   state_d = S_PAGE_WR;
                    else                            state_d = S_CMD_WR;
                end
            end
            S_DATA_WR: begin
                if (xfer_bad)                       state_d = S_FINISH;
                else if (xfer_ok && is_last)        state_d = page_new ? S_PAGE_WR : S_CMD_WR;
            end
            S_PAGE_WR: begin
                if (xfer_bad)                       state_d = S_FINISH;
                else if (xfer_ok)                   state_d = S_CMD_WR;
            end
            S_CMD_WR: begin
                if (xfer_bad)                       state_d = S_FINISH;
                else if (xfer_ok)                   state_d = S_POLL_RD;
            end
            S_POLL_RD: begin
                if (xfer_bad)                       state_d = S_FINISH;
                else if (xfer_ok) begin
                    if (!poll_busy)                 state_d = wr_q ? S_FINISH : S_DATA_RD;
                    else if (timeout)               state_d = S_FINISH;
                    else                            state_d = gap_zero ? S_POLL_RD : S_POLL_WAIT;
                end
            end
            S_POLL_WAIT: begin
                if (wait_expired)                   state_d = S_POLL_RD;
            end
            S_DATA_RD: begin
                if (xfer_bad)                       state_d = S_FINISH;
                else if (xfer_ok && is_last)        state_d = S_FINISH;
            end
            S_FINISH:                               state_d = S_IDLE;
            default:                                state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request context, page cache, counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_q <= PAGE_NONE;
            page_q  <= '0;
            off_q   <= '0;
            wr_q    <= 1'b0;
            width_q <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
            poll_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                page_q  <= req_page;
                off_q   <= req_offset;
                wr_q    <= req_write;
                width_q <= req_width;
                wdata_q <= req_wdata;
                idx_q   <= '0;
                poll_q  <= '0;
                err_q   <= 1'b0;
            end
            if (xfer_bad && state_q != S_IDLE) err_q <= 1'b1;
            if (timeout)                       err_q <= 1'b1;
            if ((state_q == S_DATA_WR || state_q == S_DATA_RD) && xfer_ok)
                idx_q <= is_last ? '0 : idx_q + 1'b1;
            if (state_q == S_PAGE_WR && xfer_ok)
                cache_q <= page_q;
            if (state_q == S_POLL_RD && xfer_ok && poll_busy)
                poll_q <= poll_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        mg_valid   = 1'b0;
        mg_write   = 1'b0;
        mg_reg     = REG_CMD;
        mg_wdata   = '0;
        unique case (state_q)
            S_DATA_WR: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_reg   = REG_DATA0 + 5'(idx_q);
                mg_wdata = wdata_q[idx_q*WORD_W +: WORD_W];
            end
            S_PAGE_WR: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_reg   = REG_PAGE;
                mg_wdata = {page_q, 8'h01};
            end
            S_CMD_WR: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_reg   = REG_CMD;
                mg_wdata = {off_q, 6'b0, wr_q ? 2'b01 : 2'b10};
            end
            S_POLL_RD: begin
                mg_valid = 1'b1;
                mg_reg   = REG_CMD;
            end
            S_DATA_RD: begin
                mg_valid = 1'b1;
                mg_reg   = REG_DATA0 + 5'(idx_q);
            end
            default: ;
        endcase
        wait_start = (state_q == S_POLL_RD) && xfer_ok && poll_busy && !timeout && !gap_zero;
        clr        = (state_q == S_IDLE) && req_valid;
        cap_en     = (state_q == S_DATA_RD) && xfer_ok;
        cap_idx    = idx_q;
        byte_only  = (width_q == WID_8);
        suppress   = err_q || wr_q;
        done       = (state_q == S_FINISH);
        done_err   = err_q;
    end

endmodule

// File: rtl/pg_reg_seq.sv
module pg_reg_seq
    import pgseq_pkg::*;
#(
    parameter int         GAP_W    = 8,
    parameter int         POLL_MAX = 5,
    parameter logic [4:0] PHY_ADDR = 5'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_page,
    input  logic [7:0]        req_offset,
    input  logic              req_write,
    input  logic [2:0]        req_width,
    input  logic [63:0]       req_wdata,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              mg_valid,
    output logic              mg_write,
    output logic [4:0]        mg_phy,
    output logic [4:0]        mg_reg,
    output logic [15:0]       mg_wdata,
    input  logic              mg_done,
    input  logic              mg_err,
    input  logic [15:0]       mg_rdata,
    output logic              done,
    output logic              done_err,
    output logic [63:0]       done_rdata
);

    logic             wait_start, wait_expired;
    logic             clr, cap_en, byte_only, suppress;
    logic [IDX_W-1:0] cap_idx;

    assign mg_phy = PHY_ADDR;

    pgseq_ctrl #(.POLL_MAX(POLL_MAX)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_page     (req_page),
        .req_offset   (req_offset),
        .req_write    (req_write),
        .req_width    (req_width),
        .req_wdata    (req_wdata),
        .mg_valid     (mg_valid),
        .mg_write     (mg_write),
        .mg_reg       (mg_reg),
        .mg_wdata     (mg_wdata),
        .mg_done      (mg_done),
        .mg_err       (mg_err),
        .poll_status  (mg_rdata[1:0]),
        .gap_zero     (poll_gap == '0),
        .wait_start   (wait_start),
        .wait_expired (wait_expired),
        .clr          (clr),
        .cap_en       (cap_en),
        .cap_idx      (cap_idx),
        .byte_only    (byte_only),
        .suppress     (suppress),
        .done         (done),
        .done_err     (done_err)
    );

    pgseq_wait #(.GAP_W(GAP_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wait_start),
        .gap     (poll_gap),
        .expired (wait_expired)
    );

    pgseq_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cap_word  (mg_rdata),
        .byte_only (byte_only),
        .suppress  (suppress),
        .rdata     (done_rdata)
    );

endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mg_valid,
    input logic [4:0]  mg_reg,
    input logic [15:0] mg_wdata,
    input logic        mg_done,
    input logic        mg_err,
    input logic        done,
    input logic        done_err,
    input logic [63:0] done_rdata
);

    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mg_valid);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && !mg_done) |=> (mg_valid && $stable(mg_reg) && $stable(mg_wdata)));

    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_done && mg_err) |=> (!mg_valid && done && done_err));

    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> (done_rdata == 64'd0));

endmodule

bind pg_reg_seq pgseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mg_valid   (mg_valid),
    .mg_reg     (mg_reg),
    .mg_wdata   (mg_wdata),
    .mg_done    (mg_done),
    .mg_err     (mg_err),
    .done       (done),
    .done_err   (done_err),
    .done_rdata (done_rdata)
);

// File: tb/pg_reg_seq_tb.sv
module pg_reg_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_page = '0;
    logic [7:0]  req_offset = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_width = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  poll_gap = '0;
    logic        mg_valid, mg_write;
    logic [4:0]  mg_phy, mg_reg;
    logic [15:0] mg_wdata;
    logic        mg_done = 1'b0;
    logic        mg_err = 1'b0;
    logic [15:0] mg_rdata = '0;
    logic        done, done_err;
    logic [63:0] done_rdata;

    always #5 clk = ~clk;

    pg_reg_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_offset(req_offset), .req_write(req_write),
        .req_width(req_width), .req_wdata(req_wdata), .poll_gap(poll_gap),
        .mg_valid(mg_valid), .mg_write(mg_write), .mg_phy(mg_phy), .mg_reg(mg_reg),
        .mg_wdata(mg_wdata), .mg_done(mg_done), .mg_err(mg_err), .mg_rdata(mg_rdata),
        .done(done), .done_err(done_err), .done_rdata(done_rdata)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // responder state
    int lat = 1;
    int lcnt = 0;
    int t_start = 0;
    int busy_left = 0;
    int err_at = 99;
    int phy_bad = 0;
    logic [7:0] s_page = '0, s_off = '0;
    int log_n = 0;
    logic        log_wr[32];
    logic [4:0]  log_reg[32];
    logic [15:0] log_dat[32];
    int          log_t[32];

    function automatic logic [15:0] exp_word(input logic [7:0] pg, input logic [7:0] of, input int i);
        exp_word = {of ^ (8'h5A + 8'(i)), pg ^ (8'hC3 + 8'(i * 17))};
    endfunction

    always @(posedge clk) begin
        if (mg_done) begin
            mg_done <= 1'b0;
            mg_err  <= 1'b0;
        end else if (rst_n && mg_valid) begin
            if (lcnt == 0) t_start = cyc;
            if (lcnt == lat) begin
                lcnt = 0;
                if (mg_phy != 5'h1E) phy_bad++;
                if (log_n < 32) begin
                    log_wr[log_n]  = mg_write;
                    log_reg[log_n] = mg_reg;
                    log_dat[log_n] = mg_write ? mg_wdata : 16'h0;
                    log_t[log_n]   = t_start;
                end
                mg_err <= (log_n == err_at);
                log_n++;
                mg_rdata <= 16'h0;
                if (mg_write) begin
                    if (mg_reg == 5'h10) s_page = mg_wdata[15:8];
                    if (mg_reg == 5'h11) s_off  = mg_wdata[15:8];
                end else if (mg_reg == 5'h11) begin
                    if (busy_left > 0) begin
                        mg_rdata <= 16'h0002;
                        busy_left--;
                    end
                end else if (mg_reg >= 5'h18) begin
                    mg_rdata <= exp_word(s_page, s_off, int'(mg_reg - 5'h18));
                end
                mg_done <= 1'b1;
            end else begin
                lcnt++;
            end
        end
    end

    // expected sequence model
    logic [7:0]  mcache = 8'hFF;
    int          exp_n;
    logic        exp_wr[32];
    logic [4:0]  exp_reg[32];
    logic [15:0] exp_dat[32];

    task automatic push(input logic w, input logic [4:0] r, input logic [15:0] d);
        exp_wr[exp_n] = w; exp_reg[exp_n] = r; exp_dat[exp_n] = d; exp_n++;
    endtask

    function automatic int nwords(input logic [2:0] wc);
        nwords = (wc <= 3'd1) ? 1 : (wc == 3'd2) ? 2 : (wc == 3'd3) ? 3 : 4;
    endfunction

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic w, input logic [7:0] pg, input logic [7:0] of,
                           input logic [2:0] wc, input logic [63:0] wd,
                           input int busy, input int eat, input logic [7:0] gap);
        int n;
        int page_idx;
        int wdog;
        logic [7:0] old;
        logic exp_err;
        logic [63:0] exp_rd;
        logic got_err;
        logic [63:0] got_rd;
        logic seq_ok;
        int npoll;
        n = nwords(wc);
        @(negedge clk);
        busy_left = busy; err_at = eat; log_n = 0; lcnt = 0;
        poll_gap = gap;
        req_page = pg; req_offset = of; req_write = w; req_width = wc; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 ready low after accept", req_ready == 1'b0, 64'(req_ready), 64'd0);
        wdog = 0;
        while (!done && wdog < 3000) begin
            @(negedge clk);
            wdog++;
        end
        if (wdog >= 3000) begin
            fails++; tests++;
            $display("FAIL watchdog R10 no done actual=0 expected=1");
        end
        got_err = done_err; got_rd = done_rdata;
        @(negedge clk);
        check("R10 done one cycle", done == 1'b0, 64'(done), 64'd0);

        // build expected
        exp_n = 0; old = mcache; page_idx = -1; exp_err = 1'b0;
        if (w) for (int i = 0; i < n; i++) push(1'b1, 5'h18 + 5'(i), wd[16*i +: 16]);
        if (pg != mcache) begin
            page_idx = exp_n;
            push(1'b1, 5'h10, {pg, 8'h01});
            mcache = pg;
        end
        push(1'b1, 5'h11, {of, w ? 8'h01 : 8'h02});
        npoll = (busy >= 5) ? 5 : busy + 1;
        for (int i = 0; i < npoll; i++) push(1'b0, 5'h11, 16'h0);
        if (busy >= 5) exp_err = 1'b1;
        else if (!w) for (int i = 0; i < n; i++) push(1'b0, 5'h18 + 5'(i), 16'h0);
        if (eat < exp_n) begin
            exp_n = eat + 1;
            exp_err = 1'b1;
            if (eat <= page_idx) mcache = old;
        end
        exp_rd = '0;
        if (!w && !exp_err) begin
            for (int i = 0; i < n; i++) exp_rd[16*i +: 16] = exp_word(pg, of, i);
            if (wc == 3'd0) exp_rd = {56'd0, exp_rd[7:0]};
        end

        seq_ok = (log_n == exp_n) && (phy_bad == 0);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (log_wr[i] != exp_wr[i] || log_reg[i] != exp_reg[i] || log_dat[i] != exp_dat[i])
                seq_ok = 1'b0;
        end
        check("R2 R3 R6 transaction sequence", seq_ok, 64'(log_n), 64'(exp_n));
        for (int i = 1; i < exp_n && i < log_n; i++) begin
            if (exp_reg[i] == 5'h11 && !exp_wr[i] && exp_reg[i-1] == 5'h11 && !exp_wr[i-1])
                check("R5 poll spacing", (log_t[i] - log_t[i-1]) == (lat + 2 + int'(gap)),
                      64'(log_t[i] - log_t[i-1]), 64'(lat + 2 + int'(gap)));
        end
        check(exp_err ? "R4 R8 error flag" : "R4 no error", got_err == exp_err, 64'(got_err), 64'(exp_err));
        check(w ? "R10 write rdata zero" : "R7 read data", got_rd == exp_rd, got_rd, exp_rd);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog global timeout");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", req_ready == 1'b1, 64'(req_ready), 64'd1);
        check("R1 no transaction after reset", mg_valid == 1'b0, 64'(mg_valid), 64'd0);
        check("R1 done low after reset", done == 1'b0, 64'(done), 64'd0);

        // R1: first access writes page even for page 0
        // R6 R7 sweep: every width, both directions, repeated and new pages, two latencies
        for (int l = 0; l < 3; l += 2) begin
            lat = l;
            for (int wr = 0; wr < 2; wr++) begin
                for (int wc = 0; wc < 5; wc++) begin
                    run_req(wr[0], 8'h00, 8'(8'h40 + wc), 3'(wc), 64'h1234_5678_9ABC_DEF0 ^ 64'(wc * 7919),
                            wc % 3, 99, 8'(wc));
                    run_req(wr[0], 8'h00, 8'(8'h80 + wc), 3'(wc), 64'hFEDC_BA98_7654_3210 + 64'(wc),
                            0, 99, 8'd0);
                    run_req(wr[0], 8'(8'h20 + wc + 8 * wr), 8'(wc), 3'(wc), 64'hA5A5_5A5A_0F0F_F0F0,
                            1, 99, 8'd1);
                end
            end
        end

        // R4 R5: busy count sweep including timeout
        lat = 1;
        for (int b = 0; b < 7; b++)
            for (int g = 0; g < 3; g++)
                run_req(1'b0, 8'h05, 8'h33, 3'd2, 64'd0, b, 99, 8'(g));

        // R8: error injected at every position, read and write, new page each time
        for (int e = 0; e < 7; e++) begin
            run_req(1'b0, 8'(8'h60 + e), 8'h11, 3'd4, 64'd0, 0, e, 8'd0);
            run_req(1'b1, 8'(8'h70 + e), 8'h22, 3'd4, 64'h0102_0304_0506_0708, 0, e, 8'd0);
            // follow-up read shows whether the page cache moved
            run_req(1'b0, 8'(8'h70 + e), 8'h01, 3'd1, 64'd0, 0, 99, 8'd0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule